// File: doc/BRIEF.md
# Periodic Event and Alarm Pulse Generator

This block turns the carry strobes of a timekeeping chain into a periodic event on an active-low, open-drain output and a status flag that always mirrors that output. A 2-bit period code picks which carry (64 Hz, seconds, minutes or hours) raises the event. No divider of its own is needed, because each event coincides with the chosen carry.

Two output modes are offered. In latched mode the output is pulled low and the flag is set on an event, and both stay so until software clears the flag. Events that arrive in the meantime are dropped. In pulse mode each event starts a fixed-width low pulse. Its width is counted in strobes of a separate time base, and by default it is 64 strobes of an 8192 Hz tick, which is 7.8125 ms. The pulse returns to open by itself, or earlier if software clears the flag. A mask bit disables the output completely. Any change to the period code or the mode bit discards a pending event.

Top module: `tick_event_gen`

## Requirements
- R1: While reset is high and in the first cycle after it, pull_low_en and irq_flag are 0.
- R2: period_sel picks the event source: 00 = carry_64hz, 01 = carry_sec, 10 = carry_min, 11 = carry_hour. An accepted event drives the output low from the cycle after the strobe. The unselected carry strobes have no effect on the output.
- R3: While mask is 1, no event is produced, and the output is released (0) in the cycle after mask is seen high.
- R4: With latch_mode = 1 (latched mode), the output stays low after an event until flag_clr. Further events while it is low change nothing.
- R5: A flag_clr strobe releases the output in the next cycle. It wins over an event strobe in the same cycle.
- R6: With latch_mode = 0 (pulse mode), the output stays low for exactly PULSE_TICKS width_tick strobes after the event and is released in the cycle after the last one. An event during a pulse restarts the count.
- R7: In pulse mode, flag_clr ends a running pulse early.
- R8: In pulse mode, with width_tick at every cycle and default PULSE_TICKS = 64, the low duty is 1/2 at a 64 Hz carry period of 128 cycles, and 1/128 at a seconds carry period of 8192 cycles.
- R9: Any change of period_sel or latch_mode clears a pending output in the next cycle. An event in the cycle of the change is dropped.
- R10: irq_flag equals pull_low_en in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| carry_64hz | input | 1 | One-cycle strobe at each 1/64 s carry |
| carry_sec | input | 1 | One-cycle strobe at each seconds carry |
| carry_min | input | 1 | One-cycle strobe at each minutes carry |
| carry_hour | input | 1 | One-cycle strobe at each hours carry |
| period_sel | input | 2 | Event source code (R2) |
| mask | input | 1 | 1 disables events and releases the output |
| latch_mode | input | 1 | 1 = latched mode, 0 = fixed pulse mode |
| flag_clr | input | 1 | One-cycle strobe: software wrote 0 to the flag |
| width_tick | input | 1 | Time-base strobe that counts the pulse width |
| pull_low_en | output | 1 | Enable of the pull-low driver (1 = pin low) |
| irq_flag | output | 1 | Status flag, equal to pull_low_en |

## Verification
Each period code is driven together with strobes on all four carries, which shows whether the decode picks the right source and ignores the others. Latched mode gets repeated events and clears, and some clears coincide with events, which separates hold, drop and priority behaviour. Pulse mode is run with a sparse width tick (to show the width follows the time base and not the clock), with retriggers, with early clears, and over whole 64 Hz and 1 s periods to measure duty. Changes of code and mode while an event is pending check that the pending event is discarded.

// File: rtl/tick_event_pkg.sv
package tick_event_pkg;
  localparam int NUM_SRC = 4;
  localparam int SEL_W = $clog2(NUM_SRC);

  typedef enum logic [SEL_W-1:0] {
    SRC_64HZ = 2'b00,
    SRC_SEC  = 2'b01,
    SRC_MIN  = 2'b10,
    SRC_HOUR = 2'b11
  } src_e;

  typedef struct packed {
    logic             latch;
    logic [SEL_W-1:0] sel;
  } cfg_t;
endpackage

// File: rtl/tick_src_select.sv
module tick_src_select #(
  parameter int N = 4,
  localparam int SW = $clog2(N)
) (
  input  logic [N-1:0]  carry_vec,
  input  logic [SW-1:0] sel,
  output logic          hit
);
  logic [N-1:0] match;

  // One comparator per source; the chosen one passes its strobe
  for (genvar g = 0; g < N; g++) begin : g_src
    assign match[g] = carry_vec[g] && (sel == SW'(g));
  end

  assign hit = |match;
endmodule

// File: rtl/cfg_change_watch.sv
module cfg_change_watch #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cfg,
  output logic         changed
);
  logic [W-1:0] prev_q;

  // Tracks the setting during reset too, so the first cycle after it compares sanely
  always_ff @(posedge clk) begin
    prev_q <= cfg;
  end

  assign changed = !rst && (cfg != prev_q);
endmodule

// File: rtl/pulse_width_timer.sv
module pulse_width_timer #(
  parameter int PULSE_TICKS = 64,
  localparam int CW = (PULSE_TICKS > 2) ? $clog2(PULSE_TICKS) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  input  logic tb_tick,
  output logic expire
);
  localparam logic [CW-1:0] LAST = CW'(PULSE_TICKS - 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                 cnt_q <= '0;
    else if (start)          cnt_q <= '0;
    else if (run && tb_tick) cnt_q <= cnt_q + 1'b1;
  end

  assign expire = run && tb_tick && (cnt_q == LAST);
endmodule

// File: rtl/tick_event_gen.sv
module tick_event_gen #(
  parameter int PULSE_TICKS = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       carry_64hz,
  input  logic       carry_sec,
  input  logic       carry_min,
  input  logic       carry_hour,
  input  logic [1:0] period_sel,
  input  logic       mask,
  input  logic       latch_mode,
  input  logic       flag_clr,
  input  logic       width_tick,
  output logic       pull_low_en,
  output logic       irq_flag
);
  import tick_event_pkg::*;

  localparam int CFG_W = $bits(cfg_t);

  logic [NUM_SRC-1:0] carry_vec;
  logic  hit, cfg_changed, kill, accept, start_pulse, run, expire;
  cfg_t  cfg;
  logic  low_q;

  // Bit order follows the source codes
  assign carry_vec = {carry_hour, carry_min, carry_sec, carry_64hz};
  assign cfg.latch = latch_mode;
  assign cfg.sel   = period_sel;

  tick_src_select #(.N(NUM_SRC)) u_sel (
    .carry_vec (carry_vec),
    .sel       (period_sel),
    .hit       (hit)
  );

  cfg_change_watch #(.W(CFG_W)) u_watch (
    .clk     (clk),
    .rst     (rst),
    .cfg     (cfg),
    .changed (cfg_changed)
  );

  // Clear sources outrank any event in the same cycle
  assign kill        = mask || flag_clr || cfg_changed;
  // Latched mode drops events while set; pulse mode retriggers
  assign accept      = hit && !kill && (!low_q || !latch_mode);
  assign start_pulse = accept && !latch_mode;
  assign run         = low_q && !latch_mode;

  pulse_width_timer #(.PULSE_TICKS(PULSE_TICKS)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .start   (start_pulse),
    .run     (run),
    .tb_tick (width_tick),
    .expire  (expire)
  );

  always_ff @(posedge clk) begin
    if (rst)         low_q <= 1'b0;
    else if (kill)   low_q <= 1'b0;
    else if (accept) low_q <= 1'b1;
    else if (expire) low_q <= 1'b0;
  end

  // One state bit feeds both the pin enable and the flag
  assign pull_low_en = low_q;
  assign irq_flag    = low_q;
endmodule

// File: rtl/tick_event_gen_chk.sv
module tick_event_gen_chk (
  input logic       clk,
  input logic       rst,
  input logic       carry_64hz,
  input logic       carry_sec,
  input logic       carry_min,
  input logic       carry_hour,
  input logic [1:0] period_sel,
  input logic       mask,
  input logic       latch_mode,
  input logic       flag_clr,
  input logic       pull_low_en,
  input logic       irq_flag
);
  assert_src_match_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(pull_low_en) |-> $past((period_sel == 2'b00 && carry_64hz) ||
                                 (period_sel == 2'b01 && carry_sec)  ||
                                 (period_sel == 2'b10 && carry_min)  ||
                                 (period_sel == 2'b11 && carry_hour)));

  assert_mask_release_R3: assert property (@(posedge clk) disable iff (rst)
    mask |=> !pull_low_en);

  assert_latch_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (latch_mode && pull_low_en && !flag_clr && !mask &&
     $stable(period_sel) && $stable(latch_mode)) |=> pull_low_en);

  assert_clear_R5: assert property (@(posedge clk) disable iff (rst)
    flag_clr |=> !irq_flag);

  assert_cfg_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (!$stable(period_sel) || !$stable(latch_mode)) |=> !pull_low_en);
endmodule

bind tick_event_gen tick_event_gen_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .carry_64hz  (carry_64hz),
  .carry_sec   (carry_sec),
  .carry_min   (carry_min),
  .carry_hour  (carry_hour),
  .period_sel  (period_sel),
  .mask        (mask),
  .latch_mode  (latch_mode),
  .flag_clr    (flag_clr),
  .pull_low_en (pull_low_en),
  .irq_flag    (irq_flag)
);

// File: tb/tick_event_gen_tb_top.sv
module tick_event_gen_tb_top;
  localparam int PT = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic c64 = 0, csec = 0, cmin = 0, chour = 0;
  logic [1:0] psel = 2'b00;
  logic mask = 0, lmode = 1, fclr = 0, wtick = 1;
  logic pull_low_en, irq_flag;

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model state
  int m_low = 0, m_cnt = 0, m_prev_sel = 0, m_prev_mode = 1;

  tick_event_gen #(.PULSE_TICKS(PT)) dut_i (
    .clk(clk), .rst(rst), .carry_64hz(c64), .carry_sec(csec),
    .carry_min(cmin), .carry_hour(chour), .period_sel(psel), .mask(mask),
    .latch_mode(lmode), .flag_clr(fclr), .width_tick(wtick),
    .pull_low_en(pull_low_en), .irq_flag(irq_flag));

  always #10 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_update();
    bit strobe;
    bit chg;
    case (psel)
      2'b00: strobe = c64;
      2'b01: strobe = csec;
      2'b10: strobe = cmin;
      default: strobe = chour;
    endcase
    chg = (int'(psel) != m_prev_sel) || (int'(lmode) != m_prev_mode);
    if (rst) m_low = 0;
    else if (mask || fclr || chg) m_low = 0;
    else if (strobe && (m_low == 0 || !lmode)) begin
      m_low = 1; m_cnt = 0;
    end else if (!lmode && m_low == 1 && wtick) begin
      m_cnt++;
      if (m_cnt == PT) m_low = 0;
    end
    m_prev_sel = int'(psel);
    m_prev_mode = int'(lmode);
  endtask

  // One clock: model follows the posedge, outputs compared at the negedge
  task automatic step(input string req);
    @(posedge clk);
    model_update();
    @(negedge clk);
    check(req, int'(pull_low_en), m_low);
    check("R10", int'(irq_flag), int'(pull_low_en));
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) step(req);
  endtask

  task automatic pulse_carry(input int which, input string req);
    c64 = (which == 0); csec = (which == 1); cmin = (which == 2); chour = (which == 3);
    step(req);
    c64 = 0; csec = 0; cmin = 0; chour = 0;
  endtask

  task automatic do_clear(input string req);
    fclr = 1; step(req); fclr = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    idle(3, "R1");
    check("R1", int'(pull_low_en), 0);
    rst = 0;
    step("R1");
    check("R1", int'(irq_flag), 0);

    // R2: each code against strobes on every source, latched mode
    for (int s = 0; s < 4; s++) begin
      psel = 2'(s); step("R9"); idle(2, "R2");
      for (int o = 0; o < 4; o++) begin
        if (o != s) begin
          pulse_carry(o, "R2");
          check("R2", int'(pull_low_en), 0);
        end
      end
      pulse_carry(s, "R2");
      check("R2", int'(pull_low_en), 1);
      do_clear("R5");
      check("R5", int'(pull_low_en), 0);
    end

    // R4: latched hold, repeated events ignored
    psel = 2'b01; step("R9");
    pulse_carry(1, "R4");
    idle(20, "R4");
    pulse_carry(1, "R4");
    check("R4", int'(pull_low_en), 1);
    idle(200, "R4");
    check("R4", int'(irq_flag), 1);
    do_clear("R4");
    check("R4", int'(irq_flag), 0);

    // R5: clear and event in the same cycle
    fclr = 1; pulse_carry(1, "R5"); fclr = 0;
    check("R5", int'(pull_low_en), 0);

    // R3: mask blocks events and releases a pending one
    pulse_carry(1, "R3");
    mask = 1; step("R3");
    check("R3", int'(pull_low_en), 0);
    pulse_carry(1, "R3");
    check("R3", int'(pull_low_en), 0);
    mask = 0; step("R3");

    // R9: config change discards pending event
    pulse_carry(1, "R9");
    psel = 2'b10; step("R9");
    check("R9", int'(pull_low_en), 0);
    pulse_carry(2, "R9");
    lmode = 0; step("R9");
    check("R9", int'(pull_low_en), 0);

    // R6: pulse width follows a sparse time base
    begin
      int lows = 0;
      pulse_carry(2, "R6");
      for (int i = 0; i < 200; i++) begin
        wtick = (i % 2 == 1);
        step("R6");
        lows += int'(pull_low_en);
      end
      wtick = 1;
      check("R6", lows + 1, 2 * PT);
    end
    // R6: retrigger mid pulse
    pulse_carry(2, "R6");
    idle(40, "R6");
    pulse_carry(2, "R6");
    idle(PT - 2, "R6");
    check("R6", int'(pull_low_en), 1);
    idle(2, "R6");
    check("R6", int'(pull_low_en), 0);

    // R7: early clear of a pulse
    pulse_carry(2, "R7");
    idle(10, "R7");
    do_clear("R7");
    check("R7", int'(pull_low_en), 0);
    idle(5, "R7");

    // R8: duty at 64 Hz and 1 s
    psel = 2'b00; step("R9");
    begin
      int lows = 0;
      for (int i = 0; i < 512; i++) begin
        c64 = (i % 128 == 0);
        step("R8");
        lows += int'(pull_low_en);
      end
      c64 = 0;
      check("R8", lows, 256);
    end
    psel = 2'b01; idle(70, "R9");
    begin
      int lows = 0;
      for (int i = 0; i < 16384; i++) begin
        csec = (i % 8192 == 0);
        step("R8");
        lows += int'(pull_low_en);
      end
      csec = 0;
      check("R8", lows, 2 * PT);
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule